// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns an unsigned binary word into packed binary-coded-decimal digits, one bit per clock. A single working register holds the decimal decades in its upper part and the binary operand in its lower part. Each step first corrects every decade, then shifts the whole register left by one place, so the operand's bits enter the decimal part most significant bit first. An N-bit word is done after exactly N steps.

The correction is made before the shift. A decade of five or more gets three added, which becomes the needed six once the shift doubles it. Because of this, no decade ever holds a value above nine, and no clean-up pass is needed at the end. The number of decades comes from the input width, as the smallest count that holds the largest input value.

A client pulses `start_i` with the operand on `bin_i` while `busy_o` is low. It then waits for the one-cycle `done_o` pulse, at which point `bcd_o` holds the result. The control is a three-state machine. `ST_IDLE` waits for a start and moves to `ST_SHIFT` when one arrives. `ST_SHIFT` makes one correct-and-shift step per cycle and moves to `ST_DONE` on its last step. `ST_DONE` raises `done_o` for one cycle, then returns to `ST_IDLE`, or goes straight back to `ST_SHIFT` if a new start is present in that cycle.

Top module: `bin2bcd_seq`

## Requirements
- R1: The number of decades D is ceil(BIN_W x log10 2), and `bcd_o` is 4*D bits wide; for BIN_W = 8, D = 3 and the largest input, 255, converts to 0x255.
- R2: For every input value, `bcd_o` on the `done_o` cycle holds its decimal digits: 4 bits per digit, least significant digit in bits [3:0], next digit in the next 4 bits up.
- R3: A conversion takes exactly BIN_W shift steps. If a start is accepted at clock edge E0, `busy_o` is high from E0 through edge E0+BIN_W, and `done_o` is high in the cycle after edge E0+BIN_W.
- R4: Every decade of the working register and of `bcd_o` holds a value from 0 to 9 at all times.
- R5: `done_o` is a single-cycle pulse. It follows a busy period and is never high together with `busy_o`.
- R6: A start while `busy_o` is high is ignored: the running conversion finishes with its original operand on schedule. Outside the `done_o` cycle, `bcd_o` holds its value even when `bin_i` changes.
- R7: After reset, `busy_o` and `done_o` are low and `bcd_o` is zero.
- R8: A start in the `done_o` cycle is accepted, so conversions can run back to back.
- R9: The input 218 (binary 11011010), entered most significant bit first, gives digits 2, 1, 8, which is `bcd_o` = 0x218.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted while `busy_o` is low |
| bin_i | input | BIN_W | Binary operand, captured on the accepted start |
| busy_o | output | 1 | High while shift steps are running |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| bcd_o | output | 4*D | Packed decimal result, held between conversions |

## Verification
The bound checker watches, on every cycle, that every decade in the working register and in the result stays within 0 to 9. It also checks that `done_o` is a lone pulse that never overlaps `busy_o`, that the busy run before it is exactly BIN_W cycles long, and that `bcd_o` changes only on a completion. Only the bench scenarios can show that the digits are numerically correct, both for the 218 case and across random and boundary operands. They also show that a start during a busy period leaves the first operand's result intact, and that a start in the done cycle begins a new conversion.

// File: rtl/bin2bcd_pkg.sv
package bin2bcd_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } conv_state_e;

    // ceil(w * log10(2)), with log10(2) approximated as 0.30103
    function automatic int decades_for(input int w);
        return (w * 30103 + 99999) / 100000;
    endfunction

endpackage

// File: rtl/bin2bcd_decade_adj.sv
module bin2bcd_decade_adj
    import bin2bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [DIGIT_W-1:0] digit_o
);

    // Pre-shift correction: five or more gets three added, so the coming
    // doubling carries into the next decade instead of forming 10..19.
    always_comb begin
        if (digit_i >= DIGIT_W'(5)) begin
            digit_o = digit_i + DIGIT_W'(3);
        end else begin
            digit_o = digit_i;
        end
    end

endmodule

// File: rtl/bin2bcd_step_counter.sv
module bin2bcd_step_counter #(
    parameter int MAX_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    output logic last_o
);

    localparam int CNT_W = $clog2(MAX_COUNT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(MAX_COUNT);
        end else if (step_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/bin2bcd_datapath.sv
module bin2bcd_datapath
    import bin2bcd_pkg::*;
#(
    parameter int BIN_W   = 8,
    parameter int NUM_DEC = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic                       step_i,
    input  logic [BIN_W-1:0]           bin_i,
    output logic [NUM_DEC*DIGIT_W-1:0] bcd_cur_o,
    output logic [NUM_DEC*DIGIT_W-1:0] bcd_next_o
);

    localparam int BCD_W = NUM_DEC * DIGIT_W;
    localparam int REG_W = BCD_W + BIN_W;

    logic [BCD_W-1:0] bcd_q;
    logic [BCD_W-1:0] bcd_adj;
    logic [BIN_W-1:0] bin_q;
    logic [REG_W-1:0] shifted;

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
        bin2bcd_decade_adj u_adj (
            .digit_i (bcd_q[g*DIGIT_W +: DIGIT_W]),
            .digit_o (bcd_adj[g*DIGIT_W +: DIGIT_W])
        );
    end

    assign shifted    = {bcd_adj, bin_q} << 1;
    assign bcd_next_o = shifted[REG_W-1:BIN_W];
    assign bcd_cur_o  = bcd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcd_q <= '0;
            bin_q <= '0;
        end else if (load_i) begin
            bcd_q <= '0;
            bin_q <= bin_i;
        end else if (step_i) begin
            bcd_q <= shifted[REG_W-1:BIN_W];
            bin_q <= shifted[BIN_W-1:0];
        end
    end

endmodule

// File: rtl/bin2bcd_seq.sv
module bin2bcd_seq
    import bin2bcd_pkg::*;
#(
    parameter int BIN_W = 8,
    localparam int NUM_DEC = decades_for(BIN_W),
    localparam int BCD_W   = NUM_DEC * DIGIT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BIN_W-1:0] bin_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [BCD_W-1:0] bcd_o
);

    conv_state_e      state_q;
    conv_state_e      state_d;
    logic             load;
    logic             step;
    logic             last_step;
    logic [BCD_W-1:0] work_bcd;
    logic [BCD_W-1:0] next_bcd;
    logic [BCD_W-1:0] result_q;

    bin2bcd_step_counter #(
        .MAX_COUNT (BIN_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step),
        .last_o (last_step)
    );

    bin2bcd_datapath #(
        .BIN_W   (BIN_W),
        .NUM_DEC (NUM_DEC)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .step_i     (step),
        .bin_i      (bin_i),
        .bcd_cur_o  (work_bcd),
        .bcd_next_o (next_bcd)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)   state_d = ST_SHIFT;
            ST_SHIFT: if (last_step) state_d = ST_DONE;
            ST_DONE:  state_d = start_i ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        load   = 1'b0;
        step   = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  load = start_i;
            ST_SHIFT: begin
                step   = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
                load   = start_i;
            end
            default: ;
        endcase
    end

    // Result register: written only on the final step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (step && last_step) begin
            result_q <= next_bcd;
        end
    end

    assign bcd_o = result_q;

endmodule

// File: rtl/bin2bcd_seq_chk.sv
module bin2bcd_seq_chk #(
    parameter int BIN_W   = 8,
    parameter int NUM_DEC = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   busy_o,
    input logic                   done_o,
    input logic [NUM_DEC*4-1:0]   bcd_o,
    input logic [NUM_DEC*4-1:0]   work_bcd
);

    localparam int RUN_W = $clog2(BIN_W + 1) + 1;

    logic             busy_q;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            run_len <= '0;
        end else begin
            busy_q <= busy_o;
            if (busy_o && !busy_q) begin
                run_len <= RUN_W'(1);
            end else if (busy_o) begin
                run_len <= run_len + RUN_W'(1);
            end
        end
    end

    for (genvar g = 0; g < NUM_DEC; g++) begin : g_digit
        a_r4_out_digit_valid: assert property (@(posedge clk) disable iff (!rst_n)
            bcd_o[g*4 +: 4] <= 4'd9);
        a_r4_work_digit_valid: assert property (@(posedge clk) disable iff (!rst_n)
            work_bcd[g*4 +: 4] <= 4'd9);
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));

    a_r3_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_len == RUN_W'(BIN_W)));

    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(bcd_o));

endmodule

bind bin2bcd_seq bin2bcd_seq_chk #(
    .BIN_W   (BIN_W),
    .NUM_DEC (NUM_DEC)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .bcd_o    (bcd_o),
    .work_bcd (work_bcd)
);

// File: tb/test_bin2bcd_seq.sv
module test_bin2bcd_seq;

    localparam int BIN_W = 8;
    localparam int NDEC  = 3;
    localparam int BCD_W = NDEC * 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [BIN_W-1:0] bin_i = '0;
    logic             busy_o;
    logic             done_o;
    logic [BCD_W-1:0] bcd_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bin2bcd_seq #(.BIN_W(BIN_W)) i_bin2bcd_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .bin_i   (bin_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .bcd_o   (bcd_o)
    );

    function automatic logic [BCD_W-1:0] ref_bcd(input int v);
        logic [BCD_W-1:0] r = '0;
        int t = v;
        for (int d = 0; d < NDEC; d++) begin
            r[d*4 +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Start a conversion, optionally poke a start mid-run, check timing and result
    task automatic convert(input int v, input string req, input bit poke);
        int k;
        @(negedge clk);
        start_i = 1'b1;
        bin_i   = BIN_W'(v);
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R3 busy after start"}, 32'(busy_o), 32'd1);
        k = 0;
        while (!done_o && k < BIN_W + 4) begin
            if (poke && k == 2) begin
                start_i = 1'b1;
                bin_i   = ~BIN_W'(v);
            end else begin
                start_i = 1'b0;
                bin_i   = BIN_W'($urandom);
            end
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        check({req, " R3 steps to done"}, 32'(k), 32'(BIN_W));
        check({req, " R5 busy low on done"}, 32'(busy_o), 32'd0);
        check({req, " R2 value"}, 32'(bcd_o), 32'(ref_bcd(v)));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [BCD_W-1:0] held;
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        // R7 reset state
        check("R7 busy", 32'(busy_o), 32'd0);
        check("R7 done", 32'(done_o), 32'd0);
        check("R7 bcd", 32'(bcd_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        convert(218, "R9", 1'b0);
        check("R9 digits 2,1,8", 32'(bcd_o), 32'h218);
        convert(255, "R1 max", 1'b0);
        check("R1 width holds max", 32'(bcd_o), 32'h255);
        convert(0,   "R2 zero", 1'b0);
        convert(1,   "R2 one", 1'b0);
        convert(99,  "R2 99", 1'b0);
        convert(100, "R2 100", 1'b0);
        convert(128, "R2 msb only", 1'b0);

        // R6 start during busy ignored
        convert(37, "R6 poke", 1'b1);
        @(negedge clk);
        check("R6 no restart after poke", 32'(busy_o), 32'd0);

        // R6 hold: output stable while bin_i wanders
        held = bcd_o;
        for (int i = 0; i < 6; i++) begin
            bin_i = BIN_W'($urandom);
            @(negedge clk);
        end
        check("R6 output held", 32'(bcd_o), 32'(held));

        // R8 back-to-back: start in done cycle
        convert(47, "R8 first", 1'b0);
        start_i = 1'b1;
        bin_i   = BIN_W'(250);
        @(negedge clk);
        start_i = 1'b0;
        check("R8 accepted in done cycle", 32'(busy_o), 32'd1);
        while (!done_o) @(negedge clk);
        check("R8 second value", 32'(bcd_o), 32'h250);

        // R2 random operands
        for (int i = 0; i < 40; i++) begin
            convert(int'($urandom_range(0, 255)), "R2 random", 1'b0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule